// File: doc/BRIEF.md
# Share-Based Masked GF(2^8) Multiplier

This block multiplies two bytes in GF(2^8) while neither byte ever appears in plain form. Each operand arrives as `NSH` Boolean shares, so the real value is the XOR of all its shares. The block returns `NSH` result shares, and the XOR of those shares equals the field product of the two hidden operands. The reduction polynomial is x^8 + x^4 + x^3 + x + 1. The share count is a parameter of at least 2, and at least 3 gives protection against second-order power analysis.

Every pair of shares (one from each operand) is multiplied by its own bit-level multiplier. In that multiplier, result bit k is the XOR of the AND terms a[i]&b[j] whose basis product x^(i+j), after reduction, has bit k set.

The cross products of different share indices are mixed with fresh random bytes before they are accumulated. This means shares of the same secret are never combined before randomness has been added. The results are registered. A new operation can be accepted on every clock.

Top module: `masked_gf_mult`

## Requirements
- R1: The XOR of the `c_sh` bytes equals the product, reduced modulo 0x11B, of XOR(`a_sh` bytes) and XOR(`b_sh` bytes). Share k occupies bits [8k+7:8k]. For example, 0x02·0x80 = 0x1B and 0x57·0x83 = 0xC1.
- R2: Each product bit is the XOR of a[i]&b[j] over the index pairs whose reduced basis product x^(i+j) has that bit set. So single-bit operands 1<<i and 1<<j give the reduced x^(i+j), for all 64 pairs.
- R3: The result is correct for the share counts 2, 3 and 4, with the shares and random bytes drawn at random.
- R4: A zero operand gives shares that XOR to 0x00, whatever the other operand is.
- R5: `out_valid` is high in exactly the cycle that follows a cycle in which `in_valid` was sampled high.
- R6: While `in_valid` is low, `c_sh` keeps its value.
- R7: Each pair of share indices i<j takes the random byte at index i·NSH − i(i+1)/2 + (j−i−1) of `rnd`. With NSH=2 this is byte 0, and output share 0 equals (a0⊗b0) XOR `rnd`.
- R8: During reset, `out_valid` is 0 and `c_sh` is all zeros.
- R9: The result is independent of how the operands are split and of the random bytes. The same secrets under different splits give the same XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Shares and randomness are valid this cycle |
| a_sh | input | NSH*8 | Shares of operand A, share k in byte k |
| b_sh | input | NSH*8 | Shares of operand B, share k in byte k |
| rnd | input | NSH*(NSH-1)/2*8 | Fresh random bytes, one for each share pair |
| out_valid | output | 1 | Result shares are valid this cycle |
| c_sh | output | NSH*8 | Result shares, share k in byte k |

## Verification
A fault in one of the index sets or in one partial-product multiplier shows up in the XOR of the output shares one cycle after the operation, but only for the operand bits that the faulty term involves. For that reason, the exhaustive single-bit sweep is the main probe of the index sets. A fault in the random-byte pairing or in the order of the correction terms leaves the share XOR wrong for most random splits, also on the next cycle. A fault in the register update shows up as `c_sh` changing while `in_valid` is low, or as `out_valid` appearing in the wrong cycle.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam logic [7:0] RED_POLY = 8'h1B;

    // x^n reduced modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] basis_pow(input int unsigned n);
        logic [7:0] v;
        v = 8'h01;
        for (int unsigned s = 0; s < n; s++) begin
            v = v[7] ? ((v << 1) ^ RED_POLY) : (v << 1);
        end
        return v;
    endfunction

    // Set of index pairs (bit i*8+j) feeding result bit k
    function automatic logic [63:0] term_set(input int unsigned k);
        logic [63:0] s;
        logic [7:0] bp;
        s = '0;
        for (int unsigned i = 0; i < 8; i++) begin
            for (int unsigned j = 0; j < 8; j++) begin
                bp = basis_pow(i + j);
                s[i*8+j] = bp[k];
            end
        end
        return s;
    endfunction

    // Random byte index for share pair lo<hi
    function automatic int unsigned pair_idx(input int unsigned lo, input int unsigned hi,
                                             input int unsigned n);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

    // Shift-and-add product, used only by the checker
    function automatic logic [7:0] gf_mul_ref(input logic [7:0] x, input logic [7:0] y);
        logic [7:0] acc, xx;
        acc = '0;
        xx  = x;
        for (int unsigned s = 0; s < 8; s++) begin
            if (y[s]) acc = acc ^ xx;
            xx = xx[7] ? ((xx << 1) ^ RED_POLY) : (xx << 1);
        end
        return acc;
    endfunction
endpackage

// File: rtl/gf8_bitmul.sv
module gf8_bitmul
    import gfm_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    output logic [BYTE_W-1:0] p_o
);
    logic [63:0] and_terms;

    // All 64 AND terms, indexed i*8+j
    genvar gi, gj, gk;
    generate
        for (gi = 0; gi < 8; gi++) begin : g_row
            for (gj = 0; gj < 8; gj++) begin : g_col
                assign and_terms[gi*8+gj] = a_i[gi] & b_i[gj];
            end
        end
        for (gk = 0; gk < 8; gk++) begin : g_bit
            localparam logic [63:0] SET_K = term_set(gk);
            assign p_o[gk] = ^(and_terms & SET_K);
        end
    endgenerate
endmodule

// File: rtl/isw_mix.sv
module isw_mix
    import gfm_pkg::*;
#(
    parameter int unsigned NSH = 3
) (
    input  logic [NSH*NSH*BYTE_W-1:0]         pp_i,
    input  logic [NSH*(NSH-1)/2*BYTE_W-1:0]   rnd_i,
    output logic [NSH*BYTE_W-1:0]             sh_o
);
    logic [BYTE_W-1:0] rm [NSH][NSH];

    genvar gi, gj;
    generate
        for (gi = 0; gi < NSH; gi++) begin : g_i
            for (gj = 0; gj < NSH; gj++) begin : g_j
                if (gi < gj) begin : g_up
                    localparam int unsigned P = pair_idx(gi, gj, NSH);
                    assign rm[gi][gj] = rnd_i[P*BYTE_W +: BYTE_W];
                end else if (gi > gj) begin : g_lo
                    localparam int unsigned P = pair_idx(gj, gi, NSH);
                    // (r XOR a_lo*b_hi) XOR a_hi*b_lo, bracket order kept
                    assign rm[gi][gj] = (rnd_i[P*BYTE_W +: BYTE_W]
                                         ^ pp_i[(gj*NSH+gi)*BYTE_W +: BYTE_W])
                                         ^ pp_i[(gi*NSH+gj)*BYTE_W +: BYTE_W];
                end else begin : g_dg
                    assign rm[gi][gj] = '0;
                end
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NSH; i++) begin
            sh_o[i*BYTE_W +: BYTE_W] = pp_i[(i*NSH+i)*BYTE_W +: BYTE_W];
            for (int j = 0; j < NSH; j++) begin
                if (j != i) sh_o[i*BYTE_W +: BYTE_W] = sh_o[i*BYTE_W +: BYTE_W] ^ rm[i][j];
            end
        end
    end
endmodule

// File: rtl/masked_gf_mult.sv
module masked_gf_mult
    import gfm_pkg::*;
#(
    parameter int unsigned NSH = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [NSH*8-1:0]                a_sh,
    input  logic [NSH*8-1:0]                b_sh,
    input  logic [NSH*(NSH-1)/2*8-1:0]      rnd,
    output logic                            out_valid,
    output logic [NSH*8-1:0]                c_sh
);
    localparam int unsigned SW = NSH * BYTE_W;
    localparam int unsigned NP = NSH * NSH;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] sh;
    } state_t;

    state_t st_d, st_q;
    logic [NP*BYTE_W-1:0] pp;
    logic [SW-1:0]        mixed;

    // One bit-level multiplier per share pair, each product kept apart
    genvar gi, gj;
    generate
        for (gi = 0; gi < NSH; gi++) begin : g_a
            for (gj = 0; gj < NSH; gj++) begin : g_b
                gf8_bitmul u_pm (
                    .a_i (a_sh[gi*BYTE_W +: BYTE_W]),
                    .b_i (b_sh[gj*BYTE_W +: BYTE_W]),
                    .p_o (pp[(gi*NSH+gj)*BYTE_W +: BYTE_W])
                );
            end
        end
    endgenerate

    isw_mix #(.NSH(NSH)) u_mix (
        .pp_i  (pp),
        .rnd_i (rnd),
        .sh_o  (mixed)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.sh = mixed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign c_sh      = st_q.sh;
endmodule

// File: rtl/masked_gf_mult_chk.sv
module masked_gf_mult_chk
    import gfm_pkg::*;
#(
    parameter int unsigned NSH = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [NSH*8-1:0]             a_sh,
    input logic [NSH*8-1:0]             b_sh,
    input logic [NSH*(NSH-1)/2*8-1:0]   rnd,
    input logic                         out_valid,
    input logic [NSH*8-1:0]             c_sh
);
    logic [7:0] a_x, b_x, c_x, ref_p;

    always_comb begin
        a_x = '0;
        b_x = '0;
        c_x = '0;
        for (int k = 0; k < NSH; k++) begin
            a_x = a_x ^ a_sh[k*8 +: 8];
            b_x = b_x ^ b_sh[k*8 +: 8];
            c_x = c_x ^ c_sh[k*8 +: 8];
        end
        ref_p = gf_mul_ref(a_x, b_x);
    end

    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c_x == $past(ref_p));
    a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_x == 8'h00 || b_x == 8'h00)) |=> c_x == 8'h00);
    a_r5_valid_after: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(c_sh));

    always_comb begin
        if (!rst_n) a_r8_reset_idle: assert (!out_valid || $isunknown(out_valid));
    end
endmodule

bind masked_gf_mult masked_gf_mult_chk #(.NSH(NSH)) u_chk (.*);

// File: tb/masked_gf_mult_bench.sv
module masked_gf_mult_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    always #5 clk = ~clk;

    logic [15:0] a2, b2, c2;  logic [7:0]  r2;  logic v2;
    logic [23:0] a3, b3, c3;  logic [23:0] r3;  logic v3;
    logic [31:0] a4, b4, c4;  logic [47:0] r4;  logic v4;

    masked_gf_mult #(.NSH(2)) u_masked_gf_mult_n2 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_sh(a2), .b_sh(b2), .rnd(r2), .out_valid(v2), .c_sh(c2));
    masked_gf_mult #(.NSH(3)) u_masked_gf_mult (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_sh(a3), .b_sh(b3), .rnd(r3), .out_valid(v3), .c_sh(c3));
    masked_gf_mult #(.NSH(4)) u_masked_gf_mult_n4 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_sh(a4), .b_sh(b4), .rnd(r4), .out_valid(v4), .c_sh(c4));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // {a, b, expected product}
    localparam logic [23:0] VEC [10] = '{
        24'h02_80_1B, 24'h57_83_C1, 24'h57_13_FE, 24'h02_87_15, 24'h00_AB_00,
        24'hAB_00_00, 24'h01_CD_CD, 24'h53_CA_01, 24'h80_02_1B, 24'h00_00_00
    };

    function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
        logic [7:0] p, xx, yy;
        p = '0; xx = x; yy = y;
        while (yy != 0) begin
            if (yy[0]) p ^= xx;
            xx = {xx[6:0], 1'b0} ^ (xx[7] ? 8'h1B : 8'h00);
            yy = yy >> 1;
        end
        return p;
    endfunction

    function automatic logic [31:0] split(input logic [7:0] s, input int n);
        logic [31:0] v;
        logic [7:0] acc;
        v = '0; acc = s;
        for (int k = 0; k < n - 1; k++) begin
            v[k*8 +: 8] = 8'($urandom);
            acc ^= v[k*8 +: 8];
        end
        v[(n-1)*8 +: 8] = acc;
        return v;
    endfunction

    function automatic logic [7:0] fold(input logic [31:0] v, input int n);
        logic [7:0] f;
        f = '0;
        for (int k = 0; k < n; k++) f ^= v[k*8 +: 8];
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [7:0] e, input string req);
        logic [31:0] t;
        logic [15:0] h2;
        logic [23:0] h3;
        logic [31:0] h4;
        @(negedge clk);
        t = split(a, 2); a2 = t[15:0];
        t = split(b, 2); b2 = t[15:0];
        t = split(a, 3); a3 = t[23:0];
        t = split(b, 3); b3 = t[23:0];
        a4 = split(a, 4); b4 = split(b, 4);
        r2 = 8'($urandom); r3 = 24'($urandom); r4 = {16'($urandom), 32'($urandom)};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(v2 && v3 && v4, {req, " R5 out_valid"}, {29'd0, v2, v3, v4}, 32'd7);
        check(fold({16'd0, c2}, 2) == e, {req, " R3 N=2"}, fold({16'd0, c2}, 2), e);
        check(fold({8'd0, c3}, 3) == e, {req, " N=3"}, fold({8'd0, c3}, 3), e);
        check(fold(c4, 4) == e, {req, " R9 N=4"}, fold(c4, 4), e);
        check(c2[7:0] == (gmul(a2[7:0], b2[7:0]) ^ r2), "R7 share0 N=2",
              c2[7:0], gmul(a2[7:0], b2[7:0]) ^ r2);
        h2 = c2; h3 = c3; h4 = c4;
        a2 = ~a2; a3 = ~a3; a4 = ~a4; r3 = ~r3;
        @(negedge clk);
        check(!v2 && !v3 && !v4, "R5 pulse one cycle", {29'd0, v2, v3, v4}, 32'd0);
        check(c2 == h2 && c3 == h3 && c4 == h4, "R6 hold", c3, h3);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        a2 = '0; b2 = '0; r2 = '0; a3 = '0; b3 = '0; r3 = '0; a4 = '0; b4 = '0; r4 = '0;
        repeat (3) @(negedge clk);
        check(!v2 && !v3 && !v4 && c2 == 0 && c3 == 0 && c4 == 0, "R8 reset state",
              c4, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R4 table walk
        for (int n = 0; n < 10; n++) begin
            run_op(VEC[n][23:16], VEC[n][15:8], VEC[n][7:0], "R1/R4 table");
        end
        // R2 single-bit basis products
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_op(8'(1 << i), 8'(1 << j), gmul(8'(1 << i), 8'(1 << j)), "R2 basis");
            end
        end
        // R4 zero with random other operand
        for (int n = 0; n < 8; n++) begin
            logic [7:0] x;
            x = 8'($urandom);
            run_op(8'h00, x, 8'h00, "R4 zero A");
            run_op(x, 8'h00, 8'h00, "R4 zero B");
        end
        // R3 / R9 random secrets, fresh splits of the same secret
        for (int n = 0; n < 200; n++) begin
            logic [7:0] x, y;
            x = 8'($urandom); y = 8'($urandom);
            run_op(x, y, gmul(x, y), "R3 random");
            run_op(x, y, gmul(x, y), "R9 resplit");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule